// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional data buses, called A and B, through a pair of storage registers and two output multiplexers. Each direction has its own register and its own capture clock. The forward register takes the A bus on a rising edge of the forward clock, and the reverse register takes the B bus on a rising edge of the reverse clock. Both registers capture on every such edge, whatever the selects and enables are doing.

Each driven side carries one of two sources, chosen by that direction's select. The first is the live value of the opposite bus. The second is the register that holds the opposite bus. The B side is driven while its enable is high. The A side is driven while its enable is low. When both sides drive and both selects pick live data, each bus repeats the value it already holds, so the value is kept without the registers.

Neither bus is a tristate net. Each side has a separate input vector, output vector and per-bit output-enable vector. The surrounding logic or the bench resolves the physical bus. A side that is not driven shows zeros on its output vector and zeros on its output-enable vector.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_fwd` with `rst` low, the forward register loads `a_in`.
- R2: On each rising edge of `clk_rev` with `rst` low, the reverse register loads `b_in`.
- R3: Capture into either register happens whatever the values of `sel_fwd`, `sel_rev`, `b_drive` and `a_drive_n`, including when neither bus is driven.
- R4: While `b_drive` is 1, `b_out` equals `a_in` when `sel_fwd` is 0 (live) and equals the forward register when `sel_fwd` is 1 (stored).
- R5: While `a_drive_n` is 0, `a_out` equals `b_in` when `sel_rev` is 0 (live) and equals the reverse register when `sel_rev` is 1 (stored).
- R6: `b_oe` is all ones while `b_drive` is 1. While `b_drive` is 0, `b_oe` and `b_out` are all zeros.
- R7: `a_oe` is all ones while `a_drive_n` is 0. While `a_drive_n` is 1, `a_oe` and `a_out` are all zeros.
- R8: With both sides driven and both selects at 1, `a_out` shows the value stored from B and `b_out` shows the value stored from A.
- R9: With both sides driven and both selects at 0, each output equals the value its own bus holds, provided the two bus inputs carry the same held value.
- R10: `rst` is synchronous and active high. A rising edge of a register's clock while `rst` is 1 clears that register to zero.
- R11: In live mode a value passes straight through and is also stored on the same edge. Switching the select to stored afterwards shows that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fwd | input | 1 | Capture clock of the A-to-B register |
| clk_rev | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, sampled by each clock |
| sel_fwd | input | 1 | B-side source: 0 live A bus, 1 stored register |
| sel_rev | input | 1 | A-side source: 0 live B bus, 1 stored register |
| b_drive | input | 1 | Drive B side when 1 |
| a_drive_n | input | 1 | Drive A side when 0 |
| a_in | input | DATA_W | Value seen on the A bus |
| a_out | output | DATA_W | Value offered to the A bus |
| a_oe | output | DATA_W | Per-bit drive enable for the A bus |
| b_in | input | DATA_W | Value seen on the B bus |
| b_out | output | DATA_W | Value offered to the B bus |
| b_oe | output | DATA_W | Per-bit drive enable for the B bus |

## Verification
The hardest state to reach from the ports is a register holding a value that was captured while its result could not be seen. This happens when the capture was made with both buses idle or with the select on live data, and it only shows up later, once the select moves to stored. The stimulus runs the two capture clocks at unrelated periods and picks the enables, selects and bus values at random between edges. It keeps its own model of both registers and checks every output against that model, so a capture that went unseen is caught whenever a later random mode exposes it. Directed steps add the cases of capture with both buses idle, pass-through followed by stored readback, and both sides driven with both selects on live data and the buses holding a common value.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

    // Source choice for one drive direction
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    // Number of transfer directions in the block
    localparam int unsigned NUM_DIR = 2;
    localparam int unsigned DIR_FWD = 0;  // A side feeds B side
    localparam int unsigned DIR_REV = 1;  // B side feeds A side

    // Turn a raw enable pin into an active-high drive qualifier
    function automatic logic drive_qual(logic raw, logic is_active_low);
        return is_active_low ? ~raw : raw;
    endfunction

    function automatic src_sel_e to_src(logic raw);
        return raw ? SRC_STORED : SRC_LIVE;
    endfunction

endpackage

// File: rtl/bus_xcvr_capture.sv
module bus_xcvr_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/bus_xcvr_drive.sv
module bus_xcvr_drive
    import bus_xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              drive_on,
    input  src_sel_e          src,
    input  logic [DATA_W-1:0] live,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] out,
    output logic [DATA_W-1:0] oe
);

    logic [DATA_W-1:0] picked;

    always_comb begin
        unique case (src)
            SRC_LIVE:   picked = live;
            SRC_STORED: picked = stored;
            default:    picked = live;
        endcase
    end

    assign out = drive_on ? picked : '0;
    assign oe  = {DATA_W{drive_on}};

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import bus_xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_fwd,
    input  logic              clk_rev,
    input  logic              rst,
    input  logic              sel_fwd,
    input  logic              sel_rev,
    input  logic              b_drive,
    input  logic              a_drive_n,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic [DATA_W-1:0] b_oe
);

    // Per-direction views: index DIR_FWD carries A to B, DIR_REV carries B to A
    logic              dir_clk   [NUM_DIR];
    logic              dir_sel   [NUM_DIR];
    logic              dir_en    [NUM_DIR];
    logic              dir_lowen [NUM_DIR];
    logic [DATA_W-1:0] dir_src   [NUM_DIR];
    logic [DATA_W-1:0] dir_q     [NUM_DIR];
    logic [DATA_W-1:0] dir_out   [NUM_DIR];
    logic [DATA_W-1:0] dir_oe    [NUM_DIR];

    assign dir_clk[DIR_FWD]   = clk_fwd;
    assign dir_clk[DIR_REV]   = clk_rev;
    assign dir_sel[DIR_FWD]   = sel_fwd;
    assign dir_sel[DIR_REV]   = sel_rev;
    assign dir_en[DIR_FWD]    = b_drive;
    assign dir_en[DIR_REV]    = a_drive_n;
    assign dir_lowen[DIR_FWD] = 1'b0;
    assign dir_lowen[DIR_REV] = 1'b1;
    assign dir_src[DIR_FWD]   = a_in;
    assign dir_src[DIR_REV]   = b_in;

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        bus_xcvr_capture #(.DATA_W(DATA_W)) i_cap (
            .clk (dir_clk[g]),
            .rst (rst),
            .d   (dir_src[g]),
            .q   (dir_q[g])
        );

        bus_xcvr_drive #(.DATA_W(DATA_W)) i_drv (
            .drive_on (drive_qual(dir_en[g], dir_lowen[g])),
            .src      (to_src(dir_sel[g])),
            .live     (dir_src[g]),
            .stored   (dir_q[g]),
            .out      (dir_out[g]),
            .oe       (dir_oe[g])
        );
    end

    logic [DATA_W-1:0] q_fwd;
    logic [DATA_W-1:0] q_rev;
    assign q_fwd = dir_q[DIR_FWD];
    assign q_rev = dir_q[DIR_REV];

    assign b_out = dir_out[DIR_FWD];
    assign b_oe  = dir_oe[DIR_FWD];
    assign a_out = dir_out[DIR_REV];
    assign a_oe  = dir_oe[DIR_REV];

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_fwd,
    input logic              clk_rev,
    input logic              rst,
    input logic              sel_fwd,
    input logic              sel_rev,
    input logic              b_drive,
    input logic              a_drive_n,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] a_out,
    input logic [DATA_W-1:0] a_oe,
    input logic [DATA_W-1:0] b_in,
    input logic [DATA_W-1:0] b_out,
    input logic [DATA_W-1:0] b_oe,
    input logic [DATA_W-1:0] q_fwd,
    input logic [DATA_W-1:0] q_rev
);

    // R1
    fwd_capture_chk: assert property (@(posedge clk_fwd) disable iff (rst)
        1'b1 |=> q_fwd == $past(a_in));

    // R2
    rev_capture_chk: assert property (@(posedge clk_rev) disable iff (rst)
        1'b1 |=> q_rev == $past(b_in));

    // R4
    b_live_chk: assert property (@(posedge clk_fwd) disable iff (rst)
        (b_drive && !sel_fwd) |-> b_out == a_in);

    // R4
    b_stored_chk: assert property (@(posedge clk_fwd) disable iff (rst)
        (b_drive && sel_fwd) |-> b_out == q_fwd);

    // R5
    a_stored_chk: assert property (@(posedge clk_fwd) disable iff (rst)
        (!a_drive_n && sel_rev) |-> a_out == q_rev);

    // R6
    b_idle_chk: assert property (@(posedge clk_fwd) disable iff (rst)
        !b_drive |-> (b_out == '0 && b_oe == '0));

    // R7
    a_idle_chk: assert property (@(posedge clk_fwd) disable iff (rst)
        a_drive_n |-> (a_out == '0 && a_oe == '0));

    // R7
    a_drive_chk: assert property (@(posedge clk_fwd) disable iff (rst)
        !a_drive_n |-> (&a_oe));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.DATA_W(DATA_W)) i_chk (
    .clk_fwd   (clk_fwd),
    .clk_rev   (clk_rev),
    .rst       (rst),
    .sel_fwd   (sel_fwd),
    .sel_rev   (sel_rev),
    .b_drive   (b_drive),
    .a_drive_n (a_drive_n),
    .a_in      (a_in),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_in      (b_in),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .q_fwd     (q_fwd),
    .q_rev     (q_rev)
);

// File: tb/test_bus_xcvr_reg.sv
`timescale 1ns/1ps
module test_bus_xcvr_reg;

    localparam int unsigned W = 8;

    logic         clk_fwd = 1'b0;
    logic         clk_rev = 1'b0;
    logic         rst = 1'b1;
    logic         sel_fwd = 1'b0, sel_rev = 1'b0;
    logic         b_drive = 1'b0, a_drive_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // 50 MHz forward clock; reverse clock on an unrelated period
    always #10 clk_fwd = ~clk_fwd;
    initial begin
        #3;
        forever #14 clk_rev = ~clk_rev;
    end

    bus_xcvr_reg #(.DATA_W(W)) i_bus_xcvr_reg (
        .clk_fwd   (clk_fwd),
        .clk_rev   (clk_rev),
        .rst       (rst),
        .sel_fwd   (sel_fwd),
        .sel_rev   (sel_rev),
        .b_drive   (b_drive),
        .a_drive_n (a_drive_n),
        .a_in      (a_in),
        .a_out     (a_out),
        .a_oe      (a_oe),
        .b_in      (b_in),
        .b_out     (b_out),
        .b_oe      (b_oe)
    );

    // Reference model of the two registers (R1, R2, R3, R10)
    logic [W-1:0] m_fwd = '0;
    logic [W-1:0] m_rev = '0;
    always @(posedge clk_fwd) m_fwd <= rst ? '0 : a_in;
    always @(posedge clk_rev) m_rev <= rst ? '0 : b_in;

    function automatic logic [W-1:0] exp_b();
        if (!b_drive) return '0;
        return sel_fwd ? m_fwd : a_in;
    endfunction

    function automatic logic [W-1:0] exp_a();
        if (a_drive_n) return '0;
        return sel_rev ? m_rev : b_in;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " R4 b_out"}, b_out, exp_b());
        check({tag, " R5 a_out"}, a_out, exp_a());
        check({tag, " R6 b_oe"}, b_oe, {W{b_drive}});
        check({tag, " R7 a_oe"}, a_oe, {W{~a_drive_n}});
    endtask

    // Move inputs only at non-integer times, away from every clock edge
    task automatic step();
        @(negedge clk_fwd);
        #0.5;
    endtask

    task automatic wait_both_edges();
        @(posedge clk_fwd);
        @(posedge clk_rev);
        @(posedge clk_fwd);
        #0.5;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0652));
        a_in = 8'hA5;
        b_in = 8'h3C;
        wait_both_edges();
        wait_both_edges();
        rst = 1'b0;
        // R10: registers cleared by reset, shown through stored mode
        sel_fwd = 1'b1; sel_rev = 1'b1; b_drive = 1'b1; a_drive_n = 1'b0;
        #1;
        check("R10 fwd cleared", b_out, '0);
        check("R10 rev cleared", a_out, '0);

        // R3: capture while both buses idle and selects live
        step();
        sel_fwd = 1'b0; sel_rev = 1'b0; b_drive = 1'b0; a_drive_n = 1'b1;
        a_in = 8'h5A; b_in = 8'hC3;
        #1;
        check("R6 idle b_out", b_out, '0);
        check("R7 idle a_out", a_out, '0);
        wait_both_edges();
        sel_fwd = 1'b1; sel_rev = 1'b1; b_drive = 1'b1; a_drive_n = 1'b0;
        a_in = 8'h00; b_in = 8'hFF;
        #1;
        // R8: both driven, both stored
        check("R3 R8 R1 fwd stored", b_out, 8'h5A);
        check("R3 R8 R2 rev stored", a_out, 8'hC3);

        // R11: live pass-through captured on the same edge
        step();
        sel_fwd = 1'b0; sel_rev = 1'b0; a_drive_n = 1'b1;
        a_in = 8'h96;
        #1;
        check("R11 live pass", b_out, 8'h96);
        wait_both_edges();
        sel_fwd = 1'b1;
        #1;
        check("R11 stored after pass", b_out, 8'h96);

        // R9: both driven, both live, bus holds a common value
        step();
        sel_fwd = 1'b0; sel_rev = 1'b0; b_drive = 1'b1; a_drive_n = 1'b0;
        a_in = 8'h7E; b_in = 8'h7E;
        #1;
        check("R9 a holds", a_out, 8'h7E);
        check("R9 b holds", b_out, 8'h7E);

        // Random modes with asynchronous clocks
        for (int i = 0; i < 3000; i++) begin
            step();
            sel_fwd   = 1'($urandom);
            sel_rev   = 1'($urandom);
            b_drive   = 1'($urandom);
            a_drive_n = 1'($urandom);
            a_in      = W'($urandom);
            b_in      = W'($urandom);
            rst       = ($urandom % 200) == 0;
            #1;
            check_all("rand");
        end

        // R10 again mid-run on both clocks
        step();
        rst = 1'b1;
        wait_both_edges();
        rst = 1'b0;
        sel_fwd = 1'b1; sel_rev = 1'b1; b_drive = 1'b1; a_drive_n = 1'b0;
        #1;
        check("R10 fwd late clear", b_out, '0);
        check("R10 rev late clear", a_out, '0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule